// File: doc/BRIEF.md
# Duplicated-Copy Double-Error Link Encoder

This block prepares a 32-bit flit for a noisy inter-switch link. The flit is first protected with a shortened single-error-correcting Hamming code of 38 bits. A single even-parity bit is then formed over that whole 38-bit codeword. Finally every codeword bit is driven on two neighbouring wires, while the parity bit is driven once. The result is a 77-wire link word. A receiver can use the two copies and the lone parity bit to correct any two wire errors. Because both wires of a pair always carry the same value, no wire ever switches against its neighbour inside a pair.

The encoder sits between a switch output port and the link drivers. A flit arrives with a valid strobe. One register stage later the coded word appears together with its own valid strobe. The register keeps its value on cycles without a valid flit, so the link wires stay quiet while the port is idle.

Top module: `lnk_dup_ecc_encoder`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and `out_link` is all zeros. This holds from the moment reset asserts, even if `in_vld` is high at that time.
- R2: `out_vld` equals the value `in_vld` had at the previous rising clock edge.
- R3: On any rising edge where `in_vld` is low, `out_link` keeps its value, whatever `in_flit` carries.
- R4: Codeword positions are numbered 1 to 38. Positions 1, 2, 4, 8, 16 and 32 hold check bits. The other 32 positions hold flit bits 0 to 31 in ascending order, so flit bit 0 sits at position 3 and flit bit 31 at position 38.
- R5: The check bit at position 2^i is the XOR of every data position whose index has bit i set. The 6-bit syndrome of the transported codeword is therefore zero.
- R6: Codeword position p drives wires 2(p-1) and 2(p-1)+1 of `out_link`, and the two wires always carry equal values.
- R7: Wire 76 carries the even parity of all 38 codeword bits. This parity is carried once, not duplicated.
- R8: When valid flits arrive on consecutive cycles, each one produces its own coded word on the following cycle, without loss or repetition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| in_vld | input | 1 | A flit is present on `in_flit` this cycle |
| in_flit | input | 32 | Uncoded flit |
| out_vld | output | 1 | `out_link` holds a freshly coded flit |
| out_link | output | 77 | Coded link word: 38 duplicated pairs followed by the parity wire |

## Verification
Two functions of the block can compete in the same cycle:
- **Reset against capture.** The bench asserts reset mid-stream while `in_vld` is high with a fresh flit. The output must clear at once and stay clear, rather than capture that flit.
- **Hold against update.** The bench alternates idle cycles, where `in_flit` is deliberately scrambled, with back-to-back valid bursts. An idle cycle must leave the word untouched, and the next valid cycle must replace it.

A behavioural reference is stepped on every clock edge and compared with both outputs on every cycle. Each delivered word is also checked on its own:
- the pair wires must be equal;
- the syndrome must be zero;
- the overall parity must be consistent.

// File: rtl/lnk_enc_pkg.sv
package lnk_enc_pkg;

  localparam int unsigned FLIT_W_DEF = 32;
  localparam int unsigned CHK_W_DEF  = 6;

  function automatic bit is_pow2(input int unsigned p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // Data index carried at codeword position p (1-based, p not a power of two).
  function automatic int unsigned data_slot(input int unsigned p);
    int unsigned n_pow;
    n_pow = 0;
    for (int unsigned q = 1; q <= p; q++) begin
      if (is_pow2(q)) n_pow++;
    end
    return p - 1 - n_pow;
  endfunction

  // Positions covered by check bit i, bit (p-1) set for position p.
  function automatic logic [63:0] cover_mask(input int unsigned i, input int unsigned code_w);
    logic [63:0] m;
    m = '0;
    for (int unsigned p = 1; p <= code_w; p++) begin
      if (((p >> i) & 1) != 0) m[p-1] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [7:0] syndrome(input logic [63:0] cw, input int unsigned code_w,
                                          input int unsigned chk_w);
    logic [7:0] s;
    s = '0;
    for (int unsigned i = 0; i < chk_w; i++) begin
      s[i] = ^(cw & cover_mask(i, code_w));
    end
    return s;
  endfunction

endpackage

// File: rtl/lnk_ham_spread.sv
module lnk_ham_spread
  import lnk_enc_pkg::*;
#(
  parameter int unsigned DATA_W = FLIT_W_DEF,
  parameter int unsigned CHK_W  = CHK_W_DEF,
  localparam int unsigned CODE_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] spread;
  logic [CHK_W-1:0]  chk;

  // Place data bits at non-power-of-two positions; check slots start at zero.
  for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
    if (is_pow2(p)) begin : g_chk
      assign spread[p-1] = 1'b0;
      assign code_o[p-1] = chk[$clog2(p)];
    end else begin : g_dat
      localparam int unsigned SLOT = data_slot(p);
      assign spread[p-1] = data_i[SLOT];
      assign code_o[p-1] = data_i[SLOT];
    end
  end

  // Each check bit is the XOR tree over the positions it covers.
  for (genvar i = 0; i < CHK_W; i++) begin : g_chk_bit
    localparam logic [63:0] MASK = cover_mask(i, CODE_W);
    assign chk[i] = ^(spread & MASK[CODE_W-1:0]);
  end

endmodule

// File: rtl/lnk_parity_fold.sv
module lnk_parity_fold #(
  parameter int unsigned WIDTH = 38
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             par_o
);

  assign par_o = ^vec_i;

endmodule

// File: rtl/lnk_pair_interleave.sv
module lnk_pair_interleave #(
  parameter int unsigned CODE_W = 38,
  localparam int unsigned LINK_W = 2 * CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              par_i,
  output logic [LINK_W-1:0] link_o
);

  for (genvar k = 0; k < CODE_W; k++) begin : g_pair
    assign link_o[2*k]   = code_i[k];
    assign link_o[2*k+1] = code_i[k];
  end

  assign link_o[LINK_W-1] = par_i;

endmodule

// File: rtl/lnk_dup_ecc_encoder.sv
module lnk_dup_ecc_encoder
  import lnk_enc_pkg::*;
#(
  parameter int unsigned DATA_W = FLIT_W_DEF,
  parameter int unsigned CHK_W  = CHK_W_DEF,
  localparam int unsigned CODE_W = DATA_W + CHK_W,
  localparam int unsigned LINK_W = 2 * CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_flit,
  output logic              out_vld,
  output logic [LINK_W-1:0] out_link
);

  logic [CODE_W-1:0] code;
  logic              par;
  logic [LINK_W-1:0] link_d;
  logic [LINK_W-1:0] word_q, word_nx;
  logic              vld_q, vld_nx;

  lnk_ham_spread #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ham (
    .data_i (in_flit),
    .code_o (code)
  );

  lnk_parity_fold #(.WIDTH(CODE_W)) u_par (
    .vec_i (code),
    .par_o (par)
  );

  lnk_pair_interleave #(.CODE_W(CODE_W)) u_ilv (
    .code_i (code),
    .par_i  (par),
    .link_o (link_d)
  );

  // Next state: explicit load enable on the word, valid tracks input.
  always_comb begin
    word_nx = word_q;
    if (in_vld) word_nx = link_d;
    vld_nx = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_nx;
      vld_q  <= vld_nx;
    end
  end

  assign out_link = word_q;
  assign out_vld  = vld_q;

  // Copies recovered from the registered word, used by the checks below.
  logic [CODE_W-1:0] copy_a, copy_b;
  always_comb begin
    for (int unsigned k = 0; k < CODE_W; k++) begin
      copy_a[k] = word_q[2*k];
      copy_b[k] = word_q[2*k+1];
    end
  end

  a_r2_vld_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  a_r2_vld_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_link));

  a_r6_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (copy_a == copy_b));

  a_r5_syndrome_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (syndrome(64'(copy_a), CODE_W, CHK_W) == 8'd0));

  a_r7_overall_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((^copy_a) == out_link[LINK_W-1]));

endmodule

// File: tb/lnk_dup_ecc_encoder_bench.sv
module lnk_dup_ecc_encoder_bench;

  localparam int DW = 32;
  localparam int CW = 38;
  localparam int LW = 77;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_vld;
  logic [DW-1:0] in_flit;
  logic          out_vld;
  logic [LW-1:0] out_link;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit run_chk = 1'b0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  lnk_dup_ecc_encoder u_lnk_dup_ecc_encoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_flit  (in_flit),
    .out_vld  (out_vld),
    .out_link (out_link)
  );

  // Behavioural reference encoder.
  function automatic logic [LW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW:1]   cw;
    logic [LW-1:0] w;
    int            idx;
    logic          pb;
    cw  = '0;
    idx = 0;
    for (int p = 1; p <= CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[idx];
        idx++;
      end
    end
    for (int c = 1; c <= CW; c = c * 2) begin
      pb = 1'b0;
      for (int q = 1; q <= CW; q++) begin
        if (((q & c) != 0) && (q != c)) pb = pb ^ cw[q];
      end
      cw[c] = pb;
    end
    pb = 1'b0;
    for (int p = 1; p <= CW; p++) pb = pb ^ cw[p];
    for (int p = 1; p <= CW; p++) begin
      w[2*(p-1)]   = cw[p];
      w[2*(p-1)+1] = cw[p];
    end
    w[LW-1] = pb;
    return w;
  endfunction

  logic          m_vld;
  logic [LW-1:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld  <= 1'b0;
      m_word <= '0;
    end else begin
      m_vld <= in_vld;
      if (in_vld) m_word <= ref_enc(in_flit);
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_word(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, plus structural checks.
  always @(negedge clk) begin
    if (run_chk) begin
      logic [CW:1] a;
      logic        s, pp;
      check_bit("R2 out_vld", out_vld, m_vld);
      check_word("R4 out_link", out_link, m_word);
      if (out_vld) begin
        for (int p = 1; p <= CW; p++) a[p] = out_link[2*(p-1)];
        for (int p = 1; p <= CW; p++) begin
          check_bit("R6 pair", out_link[2*(p-1)+1], out_link[2*(p-1)]);
        end
        for (int c = 1; c <= CW; c = c * 2) begin
          s = 1'b0;
          for (int q = 1; q <= CW; q++) if ((q & c) != 0) s = s ^ a[q];
          check_bit("R5 syndrome", s, 1'b0);
        end
        pp = 1'b0;
        for (int p = 1; p <= CW; p++) pp = pp ^ a[p];
        check_bit("R7 parity", out_link[LW-1], pp);
      end
    end
  end

  task automatic drive(input logic v, input logic [DW-1:0] d);
    @(negedge clk);
    #1;
    in_vld  = v;
    in_flit = d;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [LW-1:0] held;
    logic [LW-1:0] exp_msb;
    rst_n   = 1'b0;
    in_vld  = 1'b1;
    in_flit = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_bit("R1 reset vld", out_vld, 1'b0);
    check_word("R1 reset word", out_link, '0);
    #1;
    rst_n  = 1'b1;
    in_vld = 1'b0;
    run_chk = 1'b1;

    // R4: flit bit 0 lands at position 3, covered by checks 1 and 2.
    drive(1'b1, 32'h0000_0001);
    drive(1'b0, 32'h0);
    check_word("R4 bit0 layout", out_link, {1'b1, 70'd0, 6'h3f});

    // R4: flit bit 31 lands at position 38 = checks 2, 4, 32.
    drive(1'b1, 32'h8000_0000);
    drive(1'b0, 32'h0);
    exp_msb = '0;
    exp_msb[3:2]   = 2'b11;
    exp_msb[7:6]   = 2'b11;
    exp_msb[63:62] = 2'b11;
    exp_msb[75:74] = 2'b11;
    check_word("R4 bit31 layout", out_link, exp_msb);

    // R3: idle cycles with scrambled data leave the word untouched.
    held = out_link;
    drive(1'b0, 32'hDEAD_BEEF);
    drive(1'b0, 32'h1234_5678);
    drive(1'b0, 32'h0);
    check_word("R3 hold idle", out_link, held);
    check_bit("R3 idle vld", out_vld, 1'b0);

    // R8: back-to-back flits each appear in turn.
    drive(1'b1, 32'h0000_0000);
    drive(1'b1, 32'hFFFF_FFFF);
    check_word("R8 burst first", out_link, ref_enc(32'h0000_0000));
    drive(1'b1, 32'hAAAA_5555);
    check_word("R8 burst second", out_link, ref_enc(32'hFFFF_FFFF));
    drive(1'b0, 32'h0);
    check_word("R8 burst third", out_link, ref_enc(32'hAAAA_5555));

    // Walking ones and mixed random traffic with gaps.
    for (int i = 0; i < DW; i++) drive(1'b1, 32'h1 << i);
    for (int i = 0; i < 300; i++) drive(($urandom % 3) != 0, $urandom);

    // R1: reset wins over a valid flit in the same cycle.
    drive(1'b1, 32'hCAFE_F00D);
    @(negedge clk);
    #1;
    in_flit = 32'h0F0F_0F0F;
    rst_n   = 1'b0;
    #1;
    check_bit("R1 mid reset vld", out_vld, 1'b0);
    check_word("R1 mid reset word", out_link, '0);
    @(negedge clk);
    check_word("R1 reset held", out_link, '0);
    #1;
    rst_n  = 1'b1;
    in_vld = 1'b0;
    for (int i = 0; i < 40; i++) drive(1'b1, $urandom);
    drive(1'b0, 32'h0);
    drive(1'b0, 32'h0);

    run_chk = 1'b0;
    done    = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule